// File: doc/BRIEF.md
# Programmable Length Serial CRC Engine

This block computes a cyclic redundancy check one bit at a time over a serial message. The polynomial, the seed and the check width are loaded from configuration inputs when a frame starts. The width may be any value from 0 to 8 bits, and a width of zero means the frame carries no check field at all. The configuration is captured on the start pulse and stays fixed for the whole frame, so the inputs that feed it may change freely while a frame is in progress.

A frame opens with a one-cycle `startPulse` and continues with message bits qualified by `msgValid`, most significant bit first. The last message bit is marked by `msgEnd`. In generate mode the block then shifts its check value out on `crcBitOut`, one bit per cycle. In check mode it takes the same number of received check bits on `msgBit`/`msgValid` and compares them with its own value. Each frame closes with a one-cycle `doneStrobe`, and `matchFlag` holds the verdict until the next start.

Top module: `pl_crc_engine`

## Requirements
- R1: After reset `busy`, `doneStrobe`, `crcBitValid` and `matchFlag` are 0 and `crcValue` is 0.
- R2: `startPulse` captures `cfgPoly`, `cfgSeed`, `cfgLen` and `cfgCheck` (1 = check mode, 0 = generate mode). A `cfgLen` above 8 is used as 8. Changes on these inputs after the start have no effect until the next `startPulse`.
- R3: On start the working register L bits wide (L = effective length) is loaded with the low L bits of the seed; a frame with no message bits yields the masked seed as its check value.
- R4: For each message bit taken with `msgValid`=1 (MSB first), feedback = bit XOR register bit L-1. The register shifts left one place, is XORed with the low L bits of the polynomial when the feedback is 1, and is then masked to L bits.
- R5: In the cycle after the `msgEnd` edge, `crcValue` shows the check value in bits L-1:0 with all higher bits 0. It holds that value until the next `startPulse`. A bit that is valid in the same cycle as `msgEnd` is included.
- R6: In generate mode, starting the cycle after the `msgEnd` edge, `crcBitValid` is 1 for exactly L cycles. `crcBitOut` carries check bit L-1 first and bit 0 last.
- R7: In check mode, the next L bits taken with `msgValid`=1 after `msgEnd` are compared with check bits L-1 down to 0 in that order. `matchFlag` is 1 only if every bit agrees.
- R8: `doneStrobe` is 1 for one cycle, in the cycle after the edge that consumed the last check bit. `matchFlag` takes its new value in that same cycle (1 in generate mode) and holds it until the next `startPulse`.
- R9: With L=0 there is no check phase. `doneStrobe` comes in the cycle after the `msgEnd` edge, `matchFlag` is 1, and `crcBitValid` stays 0.
- R10: `startPulse` restarts the block from any state, dropping the frame in progress.
- R11: `msgBit` with `msgValid`=0 has no effect on the check value or on the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Opens a frame and captures configuration |
| cfgPoly | input | 8 | Polynomial, low L bits used (top term implied) |
| cfgSeed | input | 8 | Seed, low L bits used |
| cfgLen | input | 4 | Check width 0..8, larger values act as 8 |
| cfgCheck | input | 1 | 1 = check mode, 0 = generate mode |
| msgBit | input | 1 | Serial data bit (message, then received check in check mode) |
| msgValid | input | 1 | Qualifies msgBit |
| msgEnd | input | 1 | Marks the last message bit, or an empty message |
| busy | output | 1 | Frame in message or check phase |
| crcValue | output | 8 | Final check value, upper bits zero |
| crcBitOut | output | 1 | Serial check bit in generate mode |
| crcBitValid | output | 1 | Qualifies crcBitOut |
| doneStrobe | output | 1 | One-cycle end-of-frame pulse |
| matchFlag | output | 1 | Comparison verdict, held |

## Verification
Every result is registered one edge behind the stimulus that causes it. `crcValue` and the first serial bit are due in the cycle after the `msgEnd` edge, and each later serial bit follows one cycle apart. `doneStrobe` and the new `matchFlag` appear one cycle after the last check bit is consumed, or one cycle after `msgEnd` when the width is zero. The bench drives inputs and samples outputs on the falling edge, so each check reads the cycle in which the requirement says the value is due. It also checks that the strobe has dropped again one cycle later.

// File: rtl/pl_crc_pkg.sv
package pl_crc_pkg;

  // strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic loadCfg;     // capture configuration and seed
    logic shiftMsg;    // absorb one message bit
    logic captureRes;  // latch final check value
    logic shiftTail;   // shift working register without feedback
    logic cmpTail;     // compare received bit with top bit
    logic finish;      // update verdict, frame ends
  } crcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSG  = 2'd1,
    ST_TAIL = 2'd2,
    ST_DONE = 2'd3
  } crcState_t;

endpackage

// File: rtl/pl_crc_dp.sv
module pl_crc_dp
  import pl_crc_pkg::*;
#(
  parameter int MAX_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobe_t       stb,
  input  logic [MAX_W-1:0] cfgPoly,
  input  logic [MAX_W-1:0] cfgSeed,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgCheck,
  input  logic             msgBit,
  output logic [LEN_W-1:0] lenQ,
  output logic             checkQ,
  output logic             topBit,
  output logic [MAX_W-1:0] crcValue,
  output logic             matchFlag
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_W);

  logic [MAX_W-1:0] polyQ;
  logic [MAX_W-1:0] shiftQ;
  logic [MAX_W-1:0] resultQ;
  logic [MAX_W-1:0] lenMask;
  logic [MAX_W-1:0] loadMask;
  logic [MAX_W-1:0] stepVal;
  logic [MAX_W-1:0] shiftNext;
  logic [LEN_W-1:0] lenClamp;
  logic             errQ;
  logic             matchQ;
  logic             feedback;
  logic             bitMiss;

  assign lenClamp = (cfgLen > LEN_MAX) ? LEN_MAX : cfgLen;

  // per-bit masks for the held length and the length being loaded
  for (genvar g = 0; g < MAX_W; g++) begin : g_mask
    assign lenMask[g]  = (lenQ > LEN_W'(g));
    assign loadMask[g] = (lenClamp > LEN_W'(g));
  end

  // select register bit L-1
  always_comb begin
    topBit = 1'b0;
    for (int i = 0; i < MAX_W; i++) begin
      if (lenQ == LEN_W'(i + 1)) topBit = shiftQ[i];
    end
  end

  assign feedback = msgBit ^ topBit;
  assign stepVal  = ((shiftQ << 1) ^ (feedback ? polyQ : '0)) & lenMask;
  assign shiftNext = stb.shiftMsg ? stepVal : shiftQ;
  assign bitMiss  = stb.cmpTail && (msgBit != topBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ    <= '0;
      checkQ  <= 1'b0;
      polyQ   <= '0;
      shiftQ  <= '0;
      resultQ <= '0;
      errQ    <= 1'b0;
      matchQ  <= 1'b0;
    end else if (stb.loadCfg) begin
      lenQ    <= lenClamp;
      checkQ  <= cfgCheck;
      polyQ   <= cfgPoly;
      shiftQ  <= cfgSeed & loadMask;
      resultQ <= '0;
      errQ    <= 1'b0;
      matchQ  <= 1'b0;
    end else begin
      if (stb.shiftTail) begin
        shiftQ <= (shiftQ << 1) & lenMask;
      end else begin
        shiftQ <= shiftNext;
      end
      if (stb.captureRes) resultQ <= shiftNext;
      if (bitMiss) errQ <= 1'b1;
      if (stb.finish) matchQ <= !(errQ || bitMiss);
    end
  end

  assign crcValue  = resultQ;
  assign matchFlag = matchQ;

endmodule

// File: rtl/pl_crc_ctrl.sv
module pl_crc_ctrl
  import pl_crc_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             msgValid,
  input  logic             msgEnd,
  input  logic [LEN_W-1:0] lenQ,
  input  logic             checkQ,
  output crcStrobe_t       stb,
  output logic             busy,
  output logic             doneStrobe,
  output logic             crcBitValid
);

  crcState_t        stateQ, stateD;
  logic [LEN_W-1:0] cntQ, cntD;
  logic             advance;

  always_comb begin
    stb     = '0;
    stateD  = stateQ;
    cntD    = cntQ;
    advance = 1'b0;
    if (startPulse) begin
      stb.loadCfg = 1'b1;
      stateD      = ST_MSG;
    end else begin
      unique case (stateQ)
        ST_MSG: begin
          stb.shiftMsg = msgValid;
          if (msgEnd) begin
            stb.captureRes = 1'b1;
            cntD = lenQ;
            if (lenQ == '0) begin
              stb.finish = 1'b1;
              stateD     = ST_DONE;
            end else begin
              stateD = ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (!checkQ) begin
            stb.shiftTail = 1'b1;
            advance       = 1'b1;
          end else if (msgValid) begin
            stb.cmpTail   = 1'b1;
            stb.shiftTail = 1'b1;
            advance       = 1'b1;
          end
          if (advance) begin
            cntD = cntQ - 1'b1;
            if (cntQ == LEN_W'(1)) begin
              stb.finish = 1'b1;
              stateD     = ST_DONE;
            end
          end
        end
        ST_DONE: stateD = ST_IDLE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign busy        = (stateQ == ST_MSG) || (stateQ == ST_TAIL);
  assign doneStrobe  = (stateQ == ST_DONE);
  assign crcBitValid = (stateQ == ST_TAIL) && !checkQ;

endmodule

// File: rtl/pl_crc_engine.sv
module pl_crc_engine
  import pl_crc_pkg::*;
#(
  parameter int MAX_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startPulse,
  input  logic [MAX_W-1:0]             cfgPoly,
  input  logic [MAX_W-1:0]             cfgSeed,
  input  logic [$clog2(MAX_W+1)-1:0]   cfgLen,
  input  logic                         cfgCheck,
  input  logic                         msgBit,
  input  logic                         msgValid,
  input  logic                         msgEnd,
  output logic                         busy,
  output logic [MAX_W-1:0]             crcValue,
  output logic                         crcBitOut,
  output logic                         crcBitValid,
  output logic                         doneStrobe,
  output logic                         matchFlag
);

  localparam int LEN_W = $clog2(MAX_W + 1);

  crcStrobe_t       stb;
  logic [LEN_W-1:0] lenQ;
  logic             checkQ;
  logic             topBit;

  pl_crc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .msgValid    (msgValid),
    .msgEnd      (msgEnd),
    .lenQ        (lenQ),
    .checkQ      (checkQ),
    .stb         (stb),
    .busy        (busy),
    .doneStrobe  (doneStrobe),
    .crcBitValid (crcBitValid)
  );

  pl_crc_dp #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgPoly   (cfgPoly),
    .cfgSeed   (cfgSeed),
    .cfgLen    (cfgLen),
    .cfgCheck  (cfgCheck),
    .msgBit    (msgBit),
    .lenQ      (lenQ),
    .checkQ    (checkQ),
    .topBit    (topBit),
    .crcValue  (crcValue),
    .matchFlag (matchFlag)
  );

  assign crcBitOut = crcBitValid & topBit;

endmodule

// File: rtl/pl_crc_chk.sv
module pl_crc_chk (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic busy,
  input logic crcBitValid,
  input logic doneStrobe
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneStrobe && !startPulse) |=> !busy);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (busy && !doneStrobe));

  // R6
  serial_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcBitValid |-> busy);

  // R6
  serial_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> !crcBitValid);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> !busy);

endmodule

bind pl_crc_engine pl_crc_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .busy        (busy),
  .crcBitValid (crcBitValid),
  .doneStrobe  (doneStrobe)
);

// File: tb/sim_pl_crc_engine.sv
module sim_pl_crc_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] cfgPoly = '0;
  logic [7:0] cfgSeed = '0;
  logic [3:0] cfgLen = '0;
  logic       cfgCheck = 1'b0;
  logic       msgBit = 1'b0;
  logic       msgValid = 1'b0;
  logic       msgEnd = 1'b0;
  logic       busy;
  logic [7:0] crcValue;
  logic       crcBitOut;
  logic       crcBitValid;
  logic       doneStrobe;
  logic       matchFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pl_crc_engine u0 (.*);

  typedef struct packed {
    logic [3:0]  len;
    logic [7:0]  poly;
    logic [7:0]  seed;
    logic [15:0] msg;
    logic [4:0]  nBits;
    logic [7:0]  expCrc;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'd4,  8'h11, 8'h0A, 16'h0000, 5'd8, 8'h0A},
    '{4'd8,  8'h07, 8'h00, 16'h0001, 5'd8, 8'h07},
    '{4'd8,  8'h07, 8'h00, 16'h00FF, 5'd8, 8'hF3},
    '{4'd0,  8'h07, 8'hFF, 16'h00A5, 5'd8, 8'h00},
    '{4'd1,  8'h01, 8'h00, 16'h000B, 5'd4, 8'h01},
    '{4'd3,  8'h03, 8'h00, 16'h0008, 5'd4, 8'h05},
    '{4'd4,  8'h03, 8'h0F, 16'h0000, 5'd0, 8'h0F},
    '{4'd12, 8'h07, 8'h00, 16'h0001, 5'd8, 8'h07}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] refCrc(input int len, input logic [7:0] poly,
                                       input logic [7:0] seed, input logic [15:0] msg,
                                       input int n);
    logic [7:0] mask;
    logic [7:0] r;
    logic fb;
    mask = '0;
    for (int i = 0; i < len; i++) mask[i] = 1'b1;
    r = seed & mask;
    for (int i = n - 1; i >= 0; i--) begin
      fb = (len > 0) ? (msg[i] ^ r[len-1]) : 1'b0;
      r = ((r << 1) ^ (fb ? poly : 8'h00)) & mask;
    end
    return r;
  endfunction

  // runs one frame; flipIdx < 0 means received check bits are correct
  task automatic runFrame(input bit chkMode, input logic [3:0] len, input logic [7:0] poly,
                          input logic [7:0] seed, input logic [15:0] msg, input int n,
                          input logic [7:0] expCrc, input int flipIdx, input bit gaps);
    int effL;
    effL = (len > 4'd8) ? 8 : int'(len);
    @(negedge clk);
    cfgLen = len; cfgPoly = poly; cfgSeed = seed; cfgCheck = chkMode;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    // R2: configuration inputs disturbed after the start
    cfgLen = ~len; cfgPoly = ~poly; cfgSeed = ~seed; cfgCheck = ~chkMode;
    if (n == 0) begin
      msgEnd = 1'b1;
      @(negedge clk);
      msgEnd = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        if (gaps) begin
          // R11: unqualified bits
          msgValid = 1'b0; msgBit = 1'b1; msgEnd = 1'b0;
          @(negedge clk);
        end
        msgValid = 1'b1; msgBit = msg[n-1-i]; msgEnd = (i == n - 1);
        @(negedge clk);
      end
      msgValid = 1'b0; msgEnd = 1'b0; msgBit = 1'b0;
    end
    check(crcValue == expCrc, "R5 R4 R3 crcValue", crcValue, expCrc);
    if (effL == 0) begin
      check(crcBitValid == 1'b0, "R9 no serial bits", crcBitValid, 0);
    end else if (!chkMode) begin
      for (int i = 0; i < effL; i++) begin
        check(crcBitValid && (crcBitOut == expCrc[effL-1-i]), "R6 serial bit",
              {crcBitValid, crcBitOut}, {1'b1, expCrc[effL-1-i]});
        @(negedge clk);
      end
    end else begin
      for (int i = 0; i < effL; i++) begin
        if (gaps) begin
          msgValid = 1'b0; msgBit = ~expCrc[effL-1-i];
          @(negedge clk);
        end
        msgValid = 1'b1;
        msgBit = expCrc[effL-1-i] ^ (i == flipIdx);
        @(negedge clk);
      end
      msgValid = 1'b0; msgBit = 1'b0;
    end
    check(doneStrobe == 1'b1, (effL == 0) ? "R9 done timing" : "R8 done timing", doneStrobe, 1);
    check(matchFlag == ((chkMode && flipIdx >= 0 && effL > 0) ? 1'b0 : 1'b1),
          chkMode ? "R7 match verdict" : "R8 gen verdict", matchFlag,
          (chkMode && flipIdx >= 0 && effL > 0) ? 0 : 1);
    @(negedge clk);
    check(!doneStrobe && !busy, "R8 done one cycle", {doneStrobe, busy}, 0);
    check(crcValue == expCrc, "R5 value held", crcValue, expCrc);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, doneStrobe, crcBitValid, matchFlag} == 4'b0, "R1 reset flags",
          {busy, doneStrobe, crcBitValid, matchFlag}, 0);
    check(crcValue == 8'h00, "R1 reset crcValue", crcValue, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int effL;
      effL = (VECS[v].len > 4'd8) ? 8 : int'(VECS[v].len);
      check(refCrc(effL, VECS[v].poly, VECS[v].seed, VECS[v].msg, int'(VECS[v].nBits))
            == VECS[v].expCrc, "R4 table self", v, VECS[v].expCrc);
      runFrame(1'b0, VECS[v].len, VECS[v].poly, VECS[v].seed, VECS[v].msg,
               int'(VECS[v].nBits), VECS[v].expCrc, -1, v[0]);
      runFrame(1'b1, VECS[v].len, VECS[v].poly, VECS[v].seed, VECS[v].msg,
               int'(VECS[v].nBits), VECS[v].expCrc, -1, v[0]);
      runFrame(1'b1, VECS[v].len, VECS[v].poly, VECS[v].seed, VECS[v].msg,
               int'(VECS[v].nBits), VECS[v].expCrc, effL - 1, ~v[0]);
    end

    // R7: mismatch on the first (top) check bit only
    runFrame(1'b1, 4'd8, 8'h1D, 8'hFF, 16'hBEEF, 16, refCrc(8, 8'h1D, 8'hFF, 16'hBEEF, 16), 0, 1'b0);

    // R10: abandon a frame mid-message, then a fresh frame must be unaffected
    @(negedge clk);
    cfgLen = 4'd8; cfgPoly = 8'h07; cfgSeed = 8'h5A; cfgCheck = 1'b0; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; msgValid = 1'b1; msgBit = 1'b1;
    repeat (3) @(negedge clk);
    msgValid = 1'b0;
    check(busy == 1'b1, "R10 busy before restart", busy, 1);
    runFrame(1'b0, 4'd5, 8'h05, 8'h13, 16'h3C96, 16, refCrc(5, 8'h05, 8'h13, 16'h3C96, 16), -1, 1'b0);

    // R2 R3: odd widths with seed bits above the width
    runFrame(1'b0, 4'd6, 8'hA7, 8'hFF, 16'h0123, 12, refCrc(6, 8'hA7, 8'hFF, 16'h0123, 12), -1, 1'b1);
    runFrame(1'b0, 4'd15, 8'h9B, 8'h3C, 16'hFACE, 16, refCrc(8, 8'h9B, 8'h3C, 16'hFACE, 16), -1, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule